// File: doc/BRIEF.md
# GPIO Port with Alternate-Function Override

This block is one 8-pin general-purpose I/O port. Software owns three registers through a small register bus: a direction register, a data register and a pin register. A read of the pin register returns the synchronized level at the pads. A write of ones to the pin register flips the matching data bits. The port drives four pad controls per pin: output enable, output value, pull-up enable and input-enable gate. It also gives peripherals an unsynchronized copy of each gated pad input.

Every pin carries its own set of override enable/value pairs. A peripheral such as a serial interface, a timer compare output or a UART uses them to take over the pin. It can take the pull-up, the driver enable or the driven value, and it can gate the digital input or flip the data bit. Software does not have to rewrite the direction or data registers. The global pull-up disable and the sleep input are shared by all pins.

Top module: `gpio_alt_port`

## Requirements
- R1: With the pull-up override enable low, a pin's pull-up is on only when its direction bit is 0, its data bit is 1 and the global pull-up disable is 0.
- R2: With the pull-up override enable high, the pull-up equals the pull-up override value. The direction bit, the data bit and the global disable have no effect.
- R3: The output enable equals the direction override value when the direction override enable is high. Otherwise it equals the direction register bit.
- R4: While the output enable is high, the pad value is the value override when the value override enable is high, and the data bit otherwise. While the output enable is low, the pad value is 0.
- R5: In each clock cycle where a pin's toggle override is high, that data bit flips. A toggle in the same cycle as a pin-register write of 1 to the same bit gives a single flip. A toggle in the same cycle as a data-register write flips the written value.
- R6: Writing the pin register (address 0) flips every data bit written as 1. Bits written as 0 leave the data register unchanged.
- R7: The input gate equals the input-enable override value when that override enable is high. Otherwise it is open (1) while the sleep input is low and closed while sleep is high. The raw input tap is the pad input ANDed with the gate, with no register in the path.
- R8: A pin-register read returns the gated pad input through a two-flop synchronizer. A pad change made between edges becomes visible after the second following rising edge, and a closed gate reads as 0.
- R9: Asynchronous active-low reset clears the direction and data registers, so all output enables, pad values and pull-ups are 0 during reset.
- R10: A peripheral forces a pin to input while keeping the pull-up under software control. It sets both the direction and pull-up override enables, a direction override value of 0, and a pull-up value of data AND NOT disable. The pin then has output enable 0 and a pull-up that follows the data bit and the global disable.
- R11: Register addresses are 0 for pin, 1 for direction, 2 for data, and 3 unused. A write takes effect at the rising edge while the write enable is high. The read data is combinational, and it is 0 when the read enable is low or the address is 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | I/O clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 2 | Register select (0 pin, 1 direction, 2 data) |
| busWrEn | input | 1 | Write strobe |
| busRdEn | input | 1 | Read strobe |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data, combinational |
| pullDisable | input | 1 | Global pull-up disable |
| sleepReq | input | 1 | Sleep state, closes non-overridden input gates |
| ovPullEn | input | 8 | Per-pin pull-up override enable |
| ovPullVal | input | 8 | Per-pin pull-up override value |
| ovDirEn | input | 8 | Per-pin output-enable override enable |
| ovDirVal | input | 8 | Per-pin output-enable override value |
| ovValEn | input | 8 | Per-pin driven-value override enable |
| ovValVal | input | 8 | Per-pin driven-value override value |
| ovToggle | input | 8 | Per-pin data-bit toggle request |
| ovInEn | input | 8 | Per-pin input-gate override enable |
| ovInVal | input | 8 | Per-pin input-gate override value |
| padIn | input | 8 | Pad input levels |
| padOe | output | 8 | Pad output enables |
| padOut | output | 8 | Pad output values |
| padPull | output | 8 | Pad pull-up enables |
| padInGate | output | 8 | Pad digital input gates |
| rawIn | output | 8 | Gated, unsynchronized input tap for peripherals |

## Verification
A corrupted direction or data bit shows up on the same cycle at padOe, padOut or padPull for a pin without overrides, and on the next register read-back. A wrong toggle or pin-write update shows on the first read or pad sample after the edge that stored it. A synchronizer with the wrong depth shows as a read value that changes one edge too early or too late. A wrong gate or override mux shows combinationally on the pad outputs, so exhaustive sweeps of the per-pin control combinations expose it at once.

// File: rtl/gpio_alt_pkg.sv
package gpio_alt_pkg;

  typedef enum logic [1:0] {
    SEL_PIN  = 2'd0,
    SEL_DIR  = 2'd1,
    SEL_DATA = 2'd2,
    SEL_NONE = 2'd3
  } regSel_e;

  typedef struct packed {
    logic wrPin;
    logic wrDir;
    logic wrData;
    logic rdPin;
    logic rdDir;
    logic rdData;
  } busStrobe_t;

endpackage

// File: rtl/gpio_alt_ctrl.sv
module gpio_alt_ctrl
  import gpio_alt_pkg::*;
(
  input  logic [1:0] busAddr,
  input  logic       busWrEn,
  input  logic       busRdEn,
  output busStrobe_t strobe
);

  regSel_e sel;

  always_comb begin
    sel = regSel_e'(busAddr);
    strobe = '0;
    // R11: one strobe at most, by address
    unique case (sel)
      SEL_PIN: begin
        strobe.wrPin = busWrEn;
        strobe.rdPin = busRdEn;
      end
      SEL_DIR: begin
        strobe.wrDir = busWrEn;
        strobe.rdDir = busRdEn;
      end
      SEL_DATA: begin
        strobe.wrData = busWrEn;
        strobe.rdData = busRdEn;
      end
      default: strobe = '0;
    endcase
  end

endmodule

// File: rtl/gpio_alt_pin_mux.sv
module gpio_alt_pin_mux (
  input  logic dirBit,
  input  logic dataBit,
  input  logic pullDisable,
  input  logic sleepReq,
  input  logic ovPullEn,
  input  logic ovPullVal,
  input  logic ovDirEn,
  input  logic ovDirVal,
  input  logic ovValEn,
  input  logic ovValVal,
  input  logic ovInEn,
  input  logic ovInVal,
  output logic padOe,
  output logic padOut,
  output logic padPull,
  output logic padInGate
);

  logic swPull;
  logic driveVal;

  always_comb begin
    // R1: software pull-up only for input, data high, not globally disabled
    swPull = ({dirBit, dataBit, pullDisable} == 3'b010);
    // R2
    padPull = ovPullEn ? ovPullVal : swPull;
    // R3
    padOe = ovDirEn ? ovDirVal : dirBit;
    // R4
    driveVal = ovValEn ? ovValVal : dataBit;
    padOut = padOe & driveVal;
    // R7
    padInGate = ovInEn ? ovInVal : ~sleepReq;
  end

endmodule

// File: rtl/gpio_alt_datapath.sv
module gpio_alt_datapath
  import gpio_alt_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  busStrobe_t          strobe,
  input  logic [NUM_PINS-1:0] busWrData,
  output logic [NUM_PINS-1:0] busRdData,
  input  logic                pullDisable,
  input  logic                sleepReq,
  input  logic [NUM_PINS-1:0] ovPullEn,
  input  logic [NUM_PINS-1:0] ovPullVal,
  input  logic [NUM_PINS-1:0] ovDirEn,
  input  logic [NUM_PINS-1:0] ovDirVal,
  input  logic [NUM_PINS-1:0] ovValEn,
  input  logic [NUM_PINS-1:0] ovValVal,
  input  logic [NUM_PINS-1:0] ovToggle,
  input  logic [NUM_PINS-1:0] ovInEn,
  input  logic [NUM_PINS-1:0] ovInVal,
  input  logic [NUM_PINS-1:0] padIn,
  output logic [NUM_PINS-1:0] padOe,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padPull,
  output logic [NUM_PINS-1:0] padInGate,
  output logic [NUM_PINS-1:0] rawIn
);

  localparam int LAST_STAGE = SYNC_STAGES - 1;

  logic [NUM_PINS-1:0] dirReg;
  logic [NUM_PINS-1:0] dataReg;
  logic [NUM_PINS-1:0] dataNext;
  logic [NUM_PINS-1:0] flipMask;
  logic [NUM_PINS-1:0] syncStage [SYNC_STAGES];
  logic [NUM_PINS-1:0] pinSync;

  // R9, R11: direction register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dirReg <= '0;
    else if (strobe.wrDir) dirReg <= busWrData;
  end

  // R5, R6: both flip sources merge into one mask
  always_comb begin
    flipMask = ovToggle | (strobe.wrPin ? busWrData : '0);
    if (strobe.wrData) dataNext = busWrData ^ ovToggle;
    else               dataNext = dataReg ^ flipMask;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dataReg <= '0;
    else       dataReg <= dataNext;
  end

  // R3, R4, R1, R2, R7: per-pin override muxes
  for (genvar p = 0; p < NUM_PINS; p++) begin : gPin
    gpio_alt_pin_mux uMux (
      .dirBit     (dirReg[p]),
      .dataBit    (dataReg[p]),
      .pullDisable(pullDisable),
      .sleepReq   (sleepReq),
      .ovPullEn   (ovPullEn[p]),
      .ovPullVal  (ovPullVal[p]),
      .ovDirEn    (ovDirEn[p]),
      .ovDirVal   (ovDirVal[p]),
      .ovValEn    (ovValEn[p]),
      .ovValVal   (ovValVal[p]),
      .ovInEn     (ovInEn[p]),
      .ovInVal    (ovInVal[p]),
      .padOe      (padOe[p]),
      .padOut     (padOut[p]),
      .padPull    (padPull[p]),
      .padInGate  (padInGate[p])
    );
  end

  // R7: unsynchronized tap
  assign rawIn = padIn & padInGate;

  // R8: synchronizer chain
  for (genvar s = 0; s < SYNC_STAGES; s++) begin : gSync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncStage[s] <= '0;
      else if (s == 0) syncStage[s] <= rawIn;
      else syncStage[s] <= syncStage[(s == 0) ? 0 : s-1];
    end
  end
  assign pinSync = syncStage[LAST_STAGE];

  // R11: combinational read mux
  always_comb begin
    busRdData = '0;
    if (strobe.rdPin)  busRdData = pinSync;
    if (strobe.rdDir)  busRdData = dirReg;
    if (strobe.rdData) busRdData = dataReg;
  end

  // ---------------- assertions ----------------
  logic [1:0] sinceRst;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sinceRst <= '0;
    else if (sinceRst != 2'd2) sinceRst <= sinceRst + 2'd1;
  end

  assert_strobe_onehot_R11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.wrPin, strobe.wrDir, strobe.wrData}));

  assert_sync_depth_R8: assert property (@(posedge clk) disable iff (!rstN)
    (SYNC_STAGES == 2 && sinceRst == 2'd2) |-> pinSync == $past(rawIn, 2));

  always @(posedge clk) begin
    if (!rstN) begin
      assert_reset_clear_R9: assert (dirReg == '0 && dataReg == '0);
    end
  end

  for (genvar q = 0; q < NUM_PINS; q++) begin : gChk
    assert_oe_gates_out_R4: assert property (@(posedge clk) disable iff (!rstN)
      !padOe[q] |-> !padOut[q]);

    assert_output_no_pull_R1: assert property (@(posedge clk) disable iff (!rstN)
      (!ovPullEn[q] && dirReg[q]) |-> !padPull[q]);

    assert_toggle_flips_R5: assert property (@(posedge clk) disable iff (!rstN)
      (ovToggle[q] && !strobe.wrData && !strobe.wrPin) |=> dataReg[q] != $past(dataReg[q]));

    assert_pin_zero_keeps_R6: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.wrPin && !busWrData[q] && !ovToggle[q]) |=> $stable(dataReg[q]));

    assert_closed_gate_R7: assert property (@(posedge clk) disable iff (!rstN)
      !padInGate[q] |-> !rawIn[q]);
  end

endmodule

// File: rtl/gpio_alt_port.sv
module gpio_alt_port
  import gpio_alt_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [1:0]          busAddr,
  input  logic                busWrEn,
  input  logic                busRdEn,
  input  logic [NUM_PINS-1:0] busWrData,
  output logic [NUM_PINS-1:0] busRdData,
  input  logic                pullDisable,
  input  logic                sleepReq,
  input  logic [NUM_PINS-1:0] ovPullEn,
  input  logic [NUM_PINS-1:0] ovPullVal,
  input  logic [NUM_PINS-1:0] ovDirEn,
  input  logic [NUM_PINS-1:0] ovDirVal,
  input  logic [NUM_PINS-1:0] ovValEn,
  input  logic [NUM_PINS-1:0] ovValVal,
  input  logic [NUM_PINS-1:0] ovToggle,
  input  logic [NUM_PINS-1:0] ovInEn,
  input  logic [NUM_PINS-1:0] ovInVal,
  input  logic [NUM_PINS-1:0] padIn,
  output logic [NUM_PINS-1:0] padOe,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padPull,
  output logic [NUM_PINS-1:0] padInGate,
  output logic [NUM_PINS-1:0] rawIn
);

  busStrobe_t strobe;

  gpio_alt_ctrl uCtrl (
    .busAddr(busAddr),
    .busWrEn(busWrEn),
    .busRdEn(busRdEn),
    .strobe (strobe)
  );

  gpio_alt_datapath #(.NUM_PINS(NUM_PINS), .SYNC_STAGES(2)) uData (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .busWrData  (busWrData),
    .busRdData  (busRdData),
    .pullDisable(pullDisable),
    .sleepReq   (sleepReq),
    .ovPullEn   (ovPullEn),
    .ovPullVal  (ovPullVal),
    .ovDirEn    (ovDirEn),
    .ovDirVal   (ovDirVal),
    .ovValEn    (ovValEn),
    .ovValVal   (ovValVal),
    .ovToggle   (ovToggle),
    .ovInEn     (ovInEn),
    .ovInVal    (ovInVal),
    .padIn      (padIn),
    .padOe      (padOe),
    .padOut     (padOut),
    .padPull    (padPull),
    .padInGate  (padInGate),
    .rawIn      (rawIn)
  );

endmodule

// File: tb/sim_gpio_alt_port.sv
module sim_gpio_alt_port;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN;
  logic [1:0] busAddr;
  logic       busWrEn, busRdEn;
  logic [7:0] busWrData, busRdData;
  logic       pullDisable, sleepReq;
  logic [7:0] ovPullEn, ovPullVal, ovDirEn, ovDirVal, ovValEn, ovValVal;
  logic [7:0] ovToggle, ovInEn, ovInVal, padIn;
  logic [7:0] padOe, padOut, padPull, padInGate, rawIn;

  int checkCount = 0;
  int failCount = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_alt_port u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busWrData(busWrData), .busRdData(busRdData), .pullDisable(pullDisable),
    .sleepReq(sleepReq), .ovPullEn(ovPullEn), .ovPullVal(ovPullVal),
    .ovDirEn(ovDirEn), .ovDirVal(ovDirVal), .ovValEn(ovValEn), .ovValVal(ovValVal),
    .ovToggle(ovToggle), .ovInEn(ovInEn), .ovInVal(ovInVal), .padIn(padIn),
    .padOe(padOe), .padOut(padOut), .padPull(padPull), .padInGate(padInGate),
    .rawIn(rawIn)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [7:0] v);
    busAddr = a; busRdEn = 1'b1;
    #1 v = busRdData;
    busRdEn = 1'b0;
  endtask

  task automatic clearOverrides();
    ovPullEn = '0; ovPullVal = '0; ovDirEn = '0; ovDirVal = '0;
    ovValEn = '0; ovValVal = '0; ovToggle = '0; ovInEn = '0; ovInVal = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      failCount++;
      checkCount++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, dirV, dataV, expOe, expOut, expPull, gate, p1, p2;
    rstN = 1'b0;
    busAddr = '0; busWrEn = 0; busRdEn = 0; busWrData = '0;
    pullDisable = 0; sleepReq = 0; padIn = '0;
    clearOverrides();
    repeat (3) @(negedge clk);
    #1;
    // R9: pad controls during reset
    check("R9 oe in reset", padOe, 8'h00);
    check("R9 pull in reset", padPull, 8'h00);
    check("R9 out in reset", padOut, 8'h00);
    @(negedge clk);
    rstN = 1'b1;
    busRead(2'd1, v); check("R9 dir after reset", v, 8'h00);
    busRead(2'd2, v); check("R9 data after reset", v, 8'h00);

    // R11: read gating and unused address
    busWrite(2'd1, 8'h96);
    busRead(2'd1, v); check("R11 dir readback", v, 8'h96);
    busAddr = 2'd1; busRdEn = 1'b0; #1 check("R11 no read strobe", busRdData, 8'h00);
    busRead(2'd3, v); check("R11 unused addr", v, 8'h00);
    busWrite(2'd3, 8'hFF);
    busRead(2'd1, v); check("R11 unused write no dir effect", v, 8'h96);
    busRead(2'd2, v); check("R11 unused write no data effect", v, 8'h00);

    // R1-R4: sweep of all per-pin combinations
    for (int c = 0; c < 512; c++) begin
      logic [7:0] k [8];
      for (int i = 0; i < 8; i++) k[i] = 8'((c + 37 * i) & 255);
      for (int i = 0; i < 8; i++) begin dirV[i] = k[i][0]; dataV[i] = k[i][1]; end
      busWrite(2'd1, dirV);
      busWrite(2'd2, dataV);
      pullDisable = c[8];
      for (int i = 0; i < 8; i++) begin
        ovPullEn[i] = k[i][2]; ovPullVal[i] = k[i][3];
        ovDirEn[i] = k[i][4];  ovDirVal[i] = k[i][5];
        ovValEn[i] = k[i][6];  ovValVal[i] = k[i][7];
        expPull[i] = k[i][2] ? k[i][3] : (!k[i][0] && k[i][1] && !c[8]);
        expOe[i] = k[i][4] ? k[i][5] : k[i][0];
        expOut[i] = expOe[i] && (k[i][6] ? k[i][7] : k[i][1]);
      end
      #1;
      check("R1/R2 pull sweep", padPull, expPull);
      check("R3 oe sweep", padOe, expOe);
      check("R4 out sweep", padOut, expOut);
    end
    clearOverrides();
    pullDisable = 0;

    // R10: forced input keeps software pull
    busWrite(2'd1, 8'hFF);
    busWrite(2'd2, 8'h5A);
    for (int pd = 0; pd < 2; pd++) begin
      pullDisable = pd[0];
      ovDirEn = 8'hFF; ovDirVal = 8'h00; ovPullEn = 8'hFF;
      ovPullVal = 8'h5A & {8{~pd[0]}};
      #1;
      check("R10 forced input oe", padOe, 8'h00);
      check("R10 forced input pull", padPull, pd[0] ? 8'h00 : 8'h5A);
      check("R10 forced input out", padOut, 8'h00);
    end
    clearOverrides();
    pullDisable = 0;

    // R6: pin write toggles ones only; observed at pads with dir all out
    busWrite(2'd2, 8'h3C);
    busWrite(2'd0, 8'h00);
    #1 check("R6 zero pin write no effect", padOut, 8'h3C);
    busWrite(2'd0, 8'h0F);
    busRead(2'd2, v); check("R6 pin write toggles", v, 8'h33);

    // R5: toggle override
    @(negedge clk); ovToggle = 8'h81;
    @(negedge clk); ovToggle = 8'h00;
    busRead(2'd2, v); check("R5 single toggle", v, 8'hB2);
    @(negedge clk); ovToggle = 8'h01;
    @(negedge clk); @(negedge clk); ovToggle = 8'h00;
    busRead(2'd2, v); check("R5 two-cycle toggle", v, 8'hB2);
    @(negedge clk);
    busAddr = 2'd0; busWrData = 8'h03; busWrEn = 1; ovToggle = 8'h06;
    @(negedge clk); busWrEn = 0; ovToggle = 8'h00;
    busRead(2'd2, v); check("R5 toggle merged with pin write", v, 8'hB2 ^ 8'h07);
    @(negedge clk);
    busAddr = 2'd2; busWrData = 8'hF0; busWrEn = 1; ovToggle = 8'h11;
    @(negedge clk); busWrEn = 0; ovToggle = 8'h00;
    busRead(2'd2, v); check("R5 toggle with data write", v, 8'hE1);

    // R7, R8: input gate sweep and synchronizer latency
    for (int g = 0; g < 8; g++) begin
      sleepReq = g[0];
      ovInEn = g[1] ? 8'hF0 : 8'h3C;
      ovInVal = g[2] ? 8'hCC : 8'h55;
      gate = (ovInEn & ovInVal) | (~ovInEn & {8{~g[0]}});
      p1 = 8'(8'hA7 ^ (g * 29));
      p2 = ~p1 ^ 8'h18;
      padIn = p1;
      #1;
      check("R7 gate", padInGate, gate);
      check("R7 raw tap", rawIn, p1 & gate);
      repeat (3) @(negedge clk);
      busRead(2'd0, v); check("R8 settled read", v, p1 & gate);
      @(negedge clk); padIn = p2;
      #1 check("R7 raw tap immediate", rawIn, p2 & gate);
      @(negedge clk);
      busRead(2'd0, v); check("R8 one edge old value", v, p1 & gate);
      @(negedge clk);
      busRead(2'd0, v); check("R8 two edges new value", v, p2 & gate);
    end
    sleepReq = 0; clearOverrides();

    // R9: mid-run reset clears software pull configuration
    busWrite(2'd1, 8'h00);
    busWrite(2'd2, 8'hFF);
    #1 check("R1 pull before reset", padPull, 8'hFF);
    @(negedge clk); rstN = 1'b0;
    #1 check("R9 pull cleared by reset", padPull, 8'h00);
    @(negedge clk); rstN = 1'b1;
    busRead(2'd2, v); check("R9 data cleared by reset", v, 8'h00);

    finished = 1;
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

endmodule